// File: doc/BRIEF.md
# Lockable System Memory Protection Unit

This block sits on the path from many bus masters to a shared memory and checks each transaction before it goes further. Every request carries an address, a direction and the ID of the master that issued it. The block compares the request with a bank of programmable region descriptors. A request that is allowed goes out on the forward side. A request that is refused gets an access-error response and is never forwarded.

Software sets up the unit through a small word-addressed register port. Each descriptor has an inclusive address window, a two-bit right for every master, a valid flag and a lock flag. There is also a global enable and a set of error-capture registers. Once any lock flag is set, the locked descriptor and the global enable both stay frozen until reset. A privileged write therefore cannot switch protection off after the configuration is complete.

Top module: `lsmpu_top`

## Requirements
- R1: An access matches a descriptor when start <= address <= end. Both bounds are inclusive 32-bit values.
- R2: The permission word of a descriptor holds two bits for master m at bits [2m+1:2m]. 00 grants nothing. 01 grants reads only. 10 or 11 grants reads and writes. Each access is judged only by its own master's field.
- R3: A descriptor whose valid bit is clear never grants any access.
- R4: Once a descriptor's lock bit is set, writes to any of its four words are ignored until reset. Descriptors that are not locked stay writable.
- R5: Checking is on only while the enable bit (bit 31 of control word 0) is set. While it is clear, every access is forwarded without error.
- R6: While any lock bit is set, writes to the enable bit have no effect.
- R7: When checking is on, an access that no valid descriptor grants gets resp_error = 1 and fwd_valid = 0. A granted access gets resp_error = 0 and is forwarded with its address, master and direction.
- R8: When several valid descriptors cover an address, the access is allowed if any one of them grants the needed right.
- R9: A request sampled at one clock edge gets its response (resp_valid, resp_error, forward outputs) registered at that same edge. resp_valid is high for exactly one cycle per accepted request.
- R10: The first refused access while the error flag is clear sets the flag. It also captures the faulting address (word 1) and the master ID plus direction (word 2: master in the low bits, write at bit 16). Later faults leave the capture unchanged while the flag stays set.
- R11: Writing 1 to bit 0 of word 0 clears the error flag. If a refused access lands in the same cycle as the clear, the flag stays set and the new fault is captured.
- R12: Reset clears the enable, every valid bit, every lock bit, all descriptor fields, the error flag and the response outputs.
- R13: Register map by word address: 0 control (bit 31 enable, bit 1 any-lock, read-only, bit 0 error flag), 1 error address, 2 error info. Descriptor r occupies words 16+4r .. 19+4r, holding start, end, permissions and control (bit 0 valid, bit 1 lock) in that order. All of these read back on cfg_rdata.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr_en | input | 1 | Register write strobe |
| cfg_addr | input | 8 | Register word address |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data for cfg_addr (combinational) |
| req_valid | input | 1 | Access request present this cycle |
| req_addr | input | 32 | Access address |
| req_master | input | 4 | Originating master ID |
| req_write | input | 1 | 1 for a write, 0 for a read |
| resp_valid | output | 1 | Response for the request of the previous cycle |
| resp_error | output | 1 | Access refused |
| fwd_valid | output | 1 | Allowed access forwarded to memory |
| fwd_addr | output | 32 | Forwarded address |
| fwd_master | output | 4 | Forwarded master ID |
| fwd_write | output | 1 | Forwarded direction |

## Verification
Two actions can land on the error flag in the same cycle: a software write-one-to-clear and a newly refused access. The bench provokes this by driving a clearing write to word 0 and a denied request on the same clock edge. It then expects the flag to stay set, with the capture registers holding the new address, master and direction rather than the old ones. A second such pairing is a locked descriptor receiving a write while traffic is being judged against it. The bench checks that the readback is unchanged and that the verdicts match the pre-write contents.

// File: rtl/lsmpu_pkg.sv
package lsmpu_pkg;

    // Word addresses of the global registers
    localparam int unsigned CTRL_WORD     = 0;
    localparam int unsigned ERR_ADDR_WORD = 1;
    localparam int unsigned ERR_INFO_WORD = 2;
    // First word of descriptor 0; each descriptor spans four words
    localparam int unsigned RGN_BASE_WORD = 16;
    // Bit position of the direction flag in the error-info word
    localparam int unsigned ERR_WR_BIT    = 16;

    // Word order inside one descriptor
    typedef enum logic [1:0] {
        DW_START = 2'd0,
        DW_END   = 2'd1,
        DW_PERM  = 2'd2,
        DW_CTRL  = 2'd3
    } desc_word_e;

    // Two-bit per-master right: 00 none, 01 read, 1x read/write
    function automatic logic right_ok(input logic [1:0] slot, input logic is_write);
        return is_write ? slot[1] : (slot != 2'b00);
    endfunction

endpackage

// File: rtl/lsmpu_region.sv
module lsmpu_region
    import lsmpu_pkg::*;
#(
    parameter int unsigned ADDR_W      = 32,
    parameter int unsigned DATA_W      = 32,
    parameter int unsigned NUM_MASTERS = 16,
    parameter int unsigned MID_W       = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_sel,
    input  logic [1:0]        wr_word,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [1:0]        rd_word,
    output logic [DATA_W-1:0] rd_data,
    input  logic [ADDR_W-1:0] chk_addr,
    input  logic [MID_W-1:0]  chk_master,
    input  logic              chk_write,
    output logic              grant,
    output logic              locked
);

    localparam int unsigned PERM_W = 2 * NUM_MASTERS;

    typedef struct packed {
        logic [ADDR_W-1:0] lo;
        logic [ADDR_W-1:0] hi;
        logic [PERM_W-1:0] perm;
        logic              valid;
        logic              lock;
    } desc_t;

    desc_t st_d, st_q;
    logic [1:0] slot;
    logic       in_window;

    // Next-state: writes land only while the descriptor is unlocked
    always_comb begin
        st_d = st_q;
        if (wr_sel && !st_q.lock) begin
            unique case (desc_word_e'(wr_word))
                DW_START: st_d.lo    = wr_data[ADDR_W-1:0];
                DW_END:   st_d.hi    = wr_data[ADDR_W-1:0];
                DW_PERM:  st_d.perm  = wr_data[PERM_W-1:0];
                DW_CTRL: begin
                    st_d.valid = wr_data[0];
                    st_d.lock  = wr_data[1];
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // Match and right lookup for the access being judged
    always_comb begin
        slot      = st_q.perm[{chk_master, 1'b0} +: 2];
        in_window = (chk_addr >= st_q.lo) && (chk_addr <= st_q.hi);
        grant     = st_q.valid && in_window && right_ok(slot, chk_write);
    end

    assign locked = st_q.lock;

    always_comb begin
        unique case (desc_word_e'(rd_word))
            DW_START: rd_data = DATA_W'(st_q.lo);
            DW_END:   rd_data = DATA_W'(st_q.hi);
            DW_PERM:  rd_data = DATA_W'(st_q.perm);
            DW_CTRL:  rd_data = DATA_W'({st_q.lock, st_q.valid});
            default:  rd_data = '0;
        endcase
    end

    // R4: a locked descriptor keeps every field and stays locked
    assert_lock_freeze_R4: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.lock |=> ($stable(st_q.lo) && $stable(st_q.hi) && $stable(st_q.perm)
                       && $stable(st_q.valid) && st_q.lock));

    // R3: a descriptor that is not valid never grants
    assert_invalid_silent_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !locked && $past(!st_q.valid) && !st_q.valid |-> !grant);

endmodule

// File: rtl/lsmpu_err_capture.sv
module lsmpu_err_capture #(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned MID_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fault,
    input  logic [ADDR_W-1:0] fault_addr,
    input  logic [MID_W-1:0]  fault_master,
    input  logic              fault_write,
    input  logic              clr,
    output logic              flag,
    output logic [ADDR_W-1:0] cap_addr,
    output logic [MID_W-1:0]  cap_master,
    output logic              cap_write
);

    typedef struct packed {
        logic              flag;
        logic [ADDR_W-1:0] addr;
        logic [MID_W-1:0]  master;
        logic              wr;
    } cap_t;

    cap_t cap_d, cap_q;

    // A fresh fault wins over a clear landing in the same cycle
    always_comb begin
        cap_d = cap_q;
        if (clr) cap_d.flag = 1'b0;
        if (fault && (!cap_q.flag || clr)) begin
            cap_d.flag   = 1'b1;
            cap_d.addr   = fault_addr;
            cap_d.master = fault_master;
            cap_d.wr     = fault_write;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cap_q <= '0;
        else        cap_q <= cap_d;
    end

    assign flag       = cap_q.flag;
    assign cap_addr   = cap_q.addr;
    assign cap_master = cap_q.master;
    assign cap_write  = cap_q.wr;

    // R10: any refused access leaves the flag set
    assert_fault_sets_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
        fault |=> flag);

    // R10/R11: while set and not cleared, the capture holds
    assert_capture_holds_R11: assert property (@(posedge clk) disable iff (!rst_n)
        flag && !clr |=> (flag && $stable(cap_addr) && $stable(cap_master) && $stable(cap_write)));

endmodule

// File: rtl/lsmpu_top.sv
module lsmpu_top
    import lsmpu_pkg::*;
#(
    parameter int unsigned NUM_REGIONS = 24,
    parameter int unsigned NUM_MASTERS = 16,
    parameter int unsigned ADDR_W      = 32,
    parameter int unsigned DATA_W      = 32,
    parameter int unsigned CFG_AW      = 8
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           cfg_wr_en,
    input  logic [CFG_AW-1:0]              cfg_addr,
    input  logic [DATA_W-1:0]              cfg_wdata,
    output logic [DATA_W-1:0]              cfg_rdata,
    input  logic                           req_valid,
    input  logic [ADDR_W-1:0]              req_addr,
    input  logic [$clog2(NUM_MASTERS)-1:0] req_master,
    input  logic                           req_write,
    output logic                           resp_valid,
    output logic                           resp_error,
    output logic                           fwd_valid,
    output logic [ADDR_W-1:0]              fwd_addr,
    output logic [$clog2(NUM_MASTERS)-1:0] fwd_master,
    output logic                           fwd_write
);

    localparam int unsigned MID_W   = $clog2(NUM_MASTERS);
    localparam int unsigned GRP_W   = CFG_AW - 2;
    localparam int unsigned RGN_GRP = RGN_BASE_WORD / 4;

    typedef struct packed {
        logic              gen_en;
        logic              rsp_v;
        logic              rsp_e;
        logic              fwd_v;
        logic [ADDR_W-1:0] fwd_a;
        logic [MID_W-1:0]  fwd_m;
        logic              fwd_w;
    } top_st_t;

    top_st_t st_d, st_q;

    logic [NUM_REGIONS-1:0] rgn_grant;
    logic [NUM_REGIONS-1:0] rgn_lock;
    logic [DATA_W-1:0]      rgn_rd [NUM_REGIONS];

    logic              any_lock;
    logic              deny;
    logic              ctrl_hit;
    logic              err_clr;
    logic              err_flag;
    logic [ADDR_W-1:0] err_addr;
    logic [MID_W-1:0]  err_master;
    logic              err_write;

    // Descriptor slices, one per region
    for (genvar r = 0; r < NUM_REGIONS; r++) begin : g_rgn
        logic sel;
        assign sel = cfg_wr_en && (cfg_addr[CFG_AW-1:2] == GRP_W'(RGN_GRP + r));
        lsmpu_region #(
            .ADDR_W      (ADDR_W),
            .DATA_W      (DATA_W),
            .NUM_MASTERS (NUM_MASTERS),
            .MID_W       (MID_W)
        ) u_rgn (
            .clk        (clk),
            .rst_n      (rst_n),
            .wr_sel     (sel),
            .wr_word    (cfg_addr[1:0]),
            .wr_data    (cfg_wdata),
            .rd_word    (cfg_addr[1:0]),
            .rd_data    (rgn_rd[r]),
            .chk_addr   (req_addr),
            .chk_master (req_master),
            .chk_write  (req_write),
            .grant      (rgn_grant[r]),
            .locked     (rgn_lock[r])
        );
    end

    assign any_lock = |rgn_lock;
    assign ctrl_hit = cfg_wr_en && (cfg_addr == CFG_AW'(CTRL_WORD));
    assign err_clr  = ctrl_hit && cfg_wdata[0];
    assign deny     = req_valid && st_q.gen_en && !(|rgn_grant);

    lsmpu_err_capture #(
        .ADDR_W (ADDR_W),
        .MID_W  (MID_W)
    ) u_err (
        .clk          (clk),
        .rst_n        (rst_n),
        .fault        (deny),
        .fault_addr   (req_addr),
        .fault_master (req_master),
        .fault_write  (req_write),
        .clr          (err_clr),
        .flag         (err_flag),
        .cap_addr     (err_addr),
        .cap_master   (err_master),
        .cap_write    (err_write)
    );

    // Global enable, verdict and forward stage
    always_comb begin
        st_d = st_q;
        if (ctrl_hit && !any_lock) st_d.gen_en = cfg_wdata[DATA_W-1];
        st_d.rsp_v = req_valid;
        st_d.rsp_e = deny;
        st_d.fwd_v = req_valid && !deny;
        st_d.fwd_a = req_addr;
        st_d.fwd_m = req_master;
        st_d.fwd_w = req_write;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign resp_valid = st_q.rsp_v;
    assign resp_error = st_q.rsp_e;
    assign fwd_valid  = st_q.fwd_v;
    assign fwd_addr   = st_q.fwd_a;
    assign fwd_master = st_q.fwd_m;
    assign fwd_write  = st_q.fwd_w;

    // Register readback
    always_comb begin
        cfg_rdata = '0;
        if (cfg_addr[CFG_AW-1:2] == '0) begin
            unique case (cfg_addr[1:0])
                2'(CTRL_WORD): begin
                    cfg_rdata[DATA_W-1] = st_q.gen_en;
                    cfg_rdata[1]        = any_lock;
                    cfg_rdata[0]        = err_flag;
                end
                2'(ERR_ADDR_WORD): cfg_rdata = DATA_W'(err_addr);
                2'(ERR_INFO_WORD): begin
                    cfg_rdata[MID_W-1:0] = err_master;
                    cfg_rdata[ERR_WR_BIT] = err_write;
                end
                default: cfg_rdata = '0;
            endcase
        end else begin
            for (int r = 0; r < NUM_REGIONS; r++) begin
                if (cfg_addr[CFG_AW-1:2] == GRP_W'(RGN_GRP + r)) cfg_rdata = rgn_rd[r];
            end
        end
    end

    // R6: enable frozen while any descriptor is locked
    assert_lock_holds_enable_R6: assert property (@(posedge clk) disable iff (!rst_n)
        any_lock |=> $stable(st_q.gen_en));

    // R5: with checking off every request is forwarded without error
    assert_disabled_pass_R5: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !st_q.gen_en |=> (resp_valid && !resp_error && fwd_valid));

    // R9: one response per request, one cycle later
    assert_resp_timing_R9: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> resp_valid);
    assert_no_spurious_resp_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !resp_valid);

    // R7: a refused access is never forwarded
    assert_err_not_fwd_R7: assert property (@(posedge clk) disable iff (!rst_n)
        resp_error |-> (resp_valid && !fwd_valid));

endmodule

// File: tb/lsmpu_top_tb_top.sv
`timescale 1ns/1ps
module lsmpu_top_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr_en = 1'b0;
    logic [7:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        req_valid = 1'b0;
    logic [31:0] req_addr = '0;
    logic [3:0]  req_master = '0;
    logic        req_write = 1'b0;
    logic        resp_valid, resp_error, fwd_valid, fwd_write;
    logic [31:0] fwd_addr;
    logic [3:0]  fwd_master;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #4 clk = ~clk;

    lsmpu_top dut_i (
        .clk(clk), .rst_n(rst_n),
        .cfg_wr_en(cfg_wr_en), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .req_valid(req_valid), .req_addr(req_addr), .req_master(req_master), .req_write(req_write),
        .resp_valid(resp_valid), .resp_error(resp_error),
        .fwd_valid(fwd_valid), .fwd_addr(fwd_addr), .fwd_master(fwd_master), .fwd_write(fwd_write)
    );

    typedef struct packed {
        logic [31:0] addr;
        logic [3:0]  mid;
        logic        wr;
        logic        err;
    } vec_t;

    // Descriptor 0: 0x1000..0x1FFF, m0 rw, m1 read
    // Descriptor 1: 0x1800..0x27FF, m1 rw, m2 rw
    // Descriptor 2: 0x3000..0x3FFF, all rw but not valid
    // Descriptor 23: 0x8000..0x8000, m15 read
    localparam int NV = 16;
    localparam vec_t VECS [NV] = '{
        '{32'h0000_1000, 4'd0,  1'b1, 1'b0},  // R1 lower bound inclusive
        '{32'h0000_1FFF, 4'd0,  1'b0, 1'b0},  // R1 upper bound inclusive
        '{32'h0000_0FFF, 4'd5,  1'b1, 1'b1},  // R7 no descriptor covers, first fault
        '{32'h0000_2000, 4'd0,  1'b0, 1'b1},  // R1 just above descriptor 0
        '{32'h0000_1000, 4'd1,  1'b0, 1'b0},  // R2 read-only master reads
        '{32'h0000_1000, 4'd1,  1'b1, 1'b1},  // R2 read-only master writes
        '{32'h0000_1800, 4'd1,  1'b1, 1'b0},  // R8 overlap: descriptor 1 grants
        '{32'h0000_27FF, 4'd2,  1'b1, 1'b0},  // R1 end of descriptor 1
        '{32'h0000_2800, 4'd2,  1'b0, 1'b1},  // R1 past descriptor 1
        '{32'h0000_1000, 4'd3,  1'b0, 1'b1},  // R2 master with no rights
        '{32'h0000_3000, 4'd0,  1'b0, 1'b1},  // R3 invalid descriptor
        '{32'h0000_8000, 4'd15, 1'b0, 1'b0},  // R1 single-address window
        '{32'h0000_8000, 4'd15, 1'b1, 1'b1},  // R2 write on read right
        '{32'h0000_8001, 4'd15, 1'b0, 1'b1},  // R1 one past window
        '{32'h0000_7FFF, 4'd15, 1'b0, 1'b1},  // R1 one below window
        '{32'h0000_1500, 4'd2,  1'b0, 1'b1}   // R2 m2 has no right in descriptor 0
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_wr_en = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_wr_en = 1'b0;
    endtask

    task automatic cfg_read(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        cfg_addr = a;
        #1 d = cfg_rdata;
    endtask

    // Drive one request; returns at the negedge after the registering edge
    task automatic access(input logic [31:0] a, input logic [3:0] m, input logic w);
        @(negedge clk);
        req_valid = 1'b1; req_addr = a; req_master = m; req_write = w;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    function automatic logic [7:0] rw(input int r, input int w);
        return 8'(16 + 4 * r + w);
    endfunction

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] rd;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R12: reset state
        cfg_read(8'd0, rd);       chk("R12 ctrl after reset", rd, 32'h0);
        cfg_read(rw(0, 3), rd);   chk("R12 desc0 ctrl after reset", rd, 32'h0);
        chk("R12 resp_valid after reset", {31'b0, resp_valid}, 32'h0);

        // R5: checking off, everything passes
        access(32'h0000_5000, 4'd7, 1'b1);
        chk("R5 no error while disabled", {31'b0, resp_error}, 32'h0);
        chk("R5 forwarded while disabled", {31'b0, fwd_valid}, 32'h1);
        chk("R7 forward address", fwd_addr, 32'h0000_5000);
        chk("R7 forward master/dir", {27'b0, fwd_master, fwd_write}, {27'b0, 4'd7, 1'b1});

        // Configure descriptors
        cfg_write(rw(0, 0), 32'h0000_1000);
        cfg_write(rw(0, 1), 32'h0000_1FFF);
        cfg_write(rw(0, 2), 32'h0000_0006);
        cfg_write(rw(0, 3), 32'h0000_0001);
        cfg_write(rw(1, 0), 32'h0000_1800);
        cfg_write(rw(1, 1), 32'h0000_27FF);
        cfg_write(rw(1, 2), 32'h0000_0028);
        cfg_write(rw(1, 3), 32'h0000_0001);
        cfg_write(rw(2, 0), 32'h0000_3000);
        cfg_write(rw(2, 1), 32'h0000_3FFF);
        cfg_write(rw(2, 2), 32'hAAAA_AAAA);
        cfg_write(rw(23, 0), 32'h0000_8000);
        cfg_write(rw(23, 1), 32'h0000_8000);
        cfg_write(rw(23, 2), 32'h4000_0000);
        cfg_write(rw(23, 3), 32'h0000_0001);

        // R13: readback
        cfg_read(rw(0, 0), rd);  chk("R13 desc0 start", rd, 32'h0000_1000);
        cfg_read(rw(1, 2), rd);  chk("R13 desc1 perm", rd, 32'h0000_0028);
        cfg_read(rw(23, 1), rd); chk("R13 desc23 end", rd, 32'h0000_8000);

        cfg_write(8'd0, 32'h8000_0000);
        cfg_read(8'd0, rd);      chk("R5 enable readback", rd, 32'h8000_0000);

        // Vector table
        for (int i = 0; i < NV; i++) begin
            access(VECS[i].addr, VECS[i].mid, VECS[i].wr);
            chk($sformatf("R7 vector %0d resp_valid", i), {31'b0, resp_valid}, 32'h1);
            chk($sformatf("R7 vector %0d resp_error", i), {31'b0, resp_error}, {31'b0, VECS[i].err});
            chk($sformatf("R7 vector %0d fwd_valid", i), {31'b0, fwd_valid}, {31'b0, ~VECS[i].err});
        end
        @(negedge clk);
        chk("R9 single-cycle response", {31'b0, resp_valid}, 32'h0);

        // R10: first fault captured, later ones ignored
        cfg_read(8'd0, rd); chk("R10 flag set", rd, 32'h8000_0001);
        cfg_read(8'd1, rd); chk("R10 captured address", rd, 32'h0000_0FFF);
        cfg_read(8'd2, rd); chk("R10 captured master/dir", rd, 32'h0001_0005);

        // R11: write-one-to-clear
        cfg_write(8'd0, 32'h8000_0001);
        cfg_read(8'd0, rd); chk("R11 flag cleared", rd, 32'h8000_0000);

        // R11: clear and new fault on the same edge
        access(32'h0000_2000, 4'd0, 1'b0);
        cfg_read(8'd1, rd); chk("R10 new capture address", rd, 32'h0000_2000);
        @(negedge clk);
        cfg_wr_en = 1'b1; cfg_addr = 8'd0; cfg_wdata = 32'h8000_0001;
        req_valid = 1'b1; req_addr = 32'h0000_2800; req_master = 4'd2; req_write = 1'b0;
        @(negedge clk);
        cfg_wr_en = 1'b0; req_valid = 1'b0;
        chk("R11 collision error response", {31'b0, resp_error}, 32'h1);
        cfg_read(8'd0, rd); chk("R11 flag stays set on collision", rd, 32'h8000_0001);
        cfg_read(8'd1, rd); chk("R11 collision captures new address", rd, 32'h0000_2800);
        cfg_read(8'd2, rd); chk("R11 collision captures new master", rd, 32'h0000_0002);

        // R4/R6: lock descriptor 0
        cfg_write(rw(0, 3), 32'h0000_0003);
        cfg_write(rw(0, 0), 32'h0000_0000);
        cfg_read(rw(0, 0), rd);  chk("R4 locked start unchanged", rd, 32'h0000_1000);
        cfg_write(rw(0, 3), 32'h0000_0000);
        cfg_read(rw(0, 3), rd);  chk("R4 lock cannot be cleared", rd, 32'h0000_0003);
        access(32'h0000_0800, 4'd0, 1'b0);
        chk("R4 locked window still enforced", {31'b0, resp_error}, 32'h1);
        cfg_write(rw(1, 1), 32'h0000_2FFF);
        cfg_read(rw(1, 1), rd);  chk("R4 unlocked descriptor writable", rd, 32'h0000_2FFF);
        cfg_write(8'd0, 32'h0000_0000);
        cfg_read(8'd0, rd);      chk("R6 enable frozen by lock", rd, 32'h8000_0003);
        access(32'h0000_0FFF, 4'd0, 1'b0);
        chk("R6 checking still active", {31'b0, resp_error}, 32'h1);
        access(32'h0000_1000, 4'd0, 1'b1);
        chk("R6 granted access still passes", {31'b0, fwd_valid}, 32'h1);

        // R12: reset releases everything
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk); rst_n = 1'b1;
        cfg_read(8'd0, rd);      chk("R12 ctrl cleared by reset", rd, 32'h0);
        cfg_read(rw(0, 3), rd);  chk("R12 lock cleared by reset", rd, 32'h0);
        cfg_read(rw(0, 0), rd);  chk("R12 start cleared by reset", rd, 32'h0);
        access(32'h0000_0FFF, 4'd0, 1'b0);
        chk("R5 passes after reset", {31'b0, fwd_valid}, 32'h1);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule